// File: doc/BRIEF.md
# Power-Management Event and Timer Register Block

This block keeps the power-management state that system software polls and programs: a 16-bit event status word, a 16-bit event enable word, a 16-bit control word and a free-running timer whose low 24 bits are readable. Software reaches it through a small I/O window in which only the low six address bits select a register. Word accesses reach the three 16-bit registers, and a doubleword read reaches the timer. The status word is write-one-to-clear. A level interrupt is raised whenever an enabled event of the right kind is pending.

Two side channels also feed the block. The first is a power-button event input. The second is the byte written to an advanced-power-management command port, which can switch the interrupt-enable bit on or off and can pulse a system-management interrupt.

A write to the control word with the sleep-enable bit set is not stored as such. Instead the block decodes a sleep type from it and issues one of three outcomes: a one-cycle shutdown request, a one-cycle reset request combined with a wake indication and a sticky suspend-to-RAM flag, or nothing at all.

The timer advances by one on each cycle in which `tick` is high. Timer status is raised when the count reaches an overflow point, which always lies on a multiple of 2^OVF_BIT.

Top module: `pm_event_timer`

## Requirements
- R1: Register offsets on `addr` are status 0x00, enable 0x02, control 0x04 and timer 0x08. Any other offset reads as zero, and writes to it change no register.
- R2: A read at 0x08 returns the timer count in bits 23:0 with bits 31:24 zero. The count rises by one on each clock in which `tick` is high.
- R3: A write to status clears each bit that is written as one and leaves the bits written as zero unchanged.
- R4: Timer status (bit 0) reads as one once the count reaches the overflow point. After reset the overflow point is 2^OVF_BIT (0x800000 at the default). The bit stays set until software clears it.
- R5: A write that clears a set timer status bit moves the overflow point to (count + 2^OVF_BIT) with its low OVF_BIT bits cleared.
- R6: `sci` is high exactly when one of status bits 0 (timer), 5 (global lock), 8 (power button) or 10 (RTC) is set together with the same bit of enable.
- R7: A control write stores the written word with bit 13 (sleep-enable) forced to zero.
- R8: A control write with bit 13 set and bits 12:10 equal to 0 pulses `shutdown_req` for one cycle, on the clock after the write.
- R9: A control write with bit 13 set and bits 12:10 equal to 1 sets status bits 15 (wake) and 8 (power button), pulses `reset_req` for one cycle and sets `s3_flag`. `s3_flag` holds until reset. Any other sleep type causes none of these actions.
- R10: A `pwr_btn` event sets status bit 8 only while enable bit 8 is set.
- R11: An APM command byte of 0xF1 sets control bit 0, 0xF0 clears it, and any other byte leaves it unchanged.
- R12: While `smi_cfg_en` is high, every APM command write pulses `smi_pulse` for one cycle on the following clock.
- R13: After reset all registers and the count read as zero, and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 6 | Register offset within the window |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Word write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| tick | input | 1 | Timer advance enable |
| pwr_btn | input | 1 | Power-button event, one cycle |
| apm_wr | input | 1 | APM command byte strobe |
| apm_cmd | input | 8 | APM command byte |
| smi_cfg_en | input | 1 | SMI generation allowed |
| sci | output | 1 | Level system control interrupt |
| shutdown_req | output | 1 | Soft power-off request pulse |
| reset_req | output | 1 | Reset request pulse |
| s3_flag | output | 1 | Suspend-to-RAM flag, sticky |
| smi_pulse | output | 1 | System-management interrupt pulse |

## Verification
Register contents, status bits and `sci` change at the clock edge that takes a write or a `pwr_btn` event, and they can be read at the following falling edge because `rd_data` and `sci` are combinational from registers. Timer status appears in the same cycle that the count register reaches the overflow point. No extra clock is added for that. `shutdown_req`, `reset_req` and `smi_pulse` are registered, so each one is high only in the cycle after its trigger edge. The bench samples each pulse at the falling edge right after that trigger edge, then samples once more a cycle later to confirm that the pulse has dropped. For the overflow tests the bench shrinks OVF_BIT so that the boundaries can be reached within a short run.

// File: rtl/pm_event_timer.sv
module pm_event_timer #(
  parameter int TMR_W   = 24,
  parameter int EXT_W   = 32,
  parameter int OVF_BIT = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  addr,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        tick,
  input  logic        pwr_btn,
  input  logic        apm_wr,
  input  logic [7:0]  apm_cmd,
  input  logic        smi_cfg_en,
  output logic        sci,
  output logic        shutdown_req,
  output logic        reset_req,
  output logic        s3_flag,
  output logic        smi_pulse
);

  localparam logic [5:0] OFS_STS = 6'h00;
  localparam logic [5:0] OFS_EN  = 6'h02;
  localparam logic [5:0] OFS_CTL = 6'h04;
  localparam logic [5:0] OFS_TMR = 6'h08;
  localparam int B_TMR = 0;
  localparam int B_GBL = 5;
  localparam int B_PWR = 8;
  localparam int B_RTC = 10;
  localparam int B_WAK = 15;
  localparam int B_SCE = 0;
  localparam int B_SLP = 13;
  localparam logic [15:0] SCI_MASK = 16'((1 << B_TMR) | (1 << B_GBL) | (1 << B_PWR) | (1 << B_RTC));
  localparam logic [EXT_W-1:0] STEP = EXT_W'(1) << OVF_BIT;
  localparam logic [7:0] APM_ON  = 8'hF1;
  localparam logic [7:0] APM_OFF = 8'hF0;

  logic [15:0]      sts_q, en_q, ctl_q, sts_d;
  logic [EXT_W-1:0] cnt_q, tgt_q;

  wire sts_wr   = wr_en && addr == OFS_STS;
  wire en_wr    = wr_en && addr == OFS_EN;
  wire ctl_wr   = wr_en && addr == OFS_CTL;
  wire tmr_hit  = cnt_q >= tgt_q;
  wire [15:0] sts_eff = sts_q | (16'(tmr_hit) << B_TMR);
  wire tmr_clr  = sts_wr && wr_data[B_TMR] && sts_eff[B_TMR];
  wire slp      = ctl_wr && wr_data[B_SLP];
  wire [2:0] slp_typ = wr_data[12:10];
  wire slp_off  = slp && slp_typ == 3'd0;
  wire slp_s3   = slp && slp_typ == 3'd1;

  assign sci = |(sts_eff & en_q & SCI_MASK);

  always_comb begin
    sts_d = sts_eff;
    if (sts_wr) sts_d = sts_d & ~wr_data;
    if (pwr_btn && en_q[B_PWR]) sts_d[B_PWR] = 1'b1;
    if (slp_s3) begin
      sts_d[B_PWR] = 1'b1;
      sts_d[B_WAK] = 1'b1;
    end
  end

  always_comb begin
    case (addr)
      OFS_STS: rd_data = {16'h0, sts_eff};
      OFS_EN:  rd_data = {16'h0, en_q};
      OFS_CTL: rd_data = {16'h0, ctl_q};
      OFS_TMR: rd_data = 32'(cnt_q[TMR_W-1:0]);
      default: rd_data = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q        <= '0;
      en_q         <= '0;
      ctl_q        <= '0;
      cnt_q        <= '0;
      tgt_q        <= STEP;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
      s3_flag      <= 1'b0;
      smi_pulse    <= 1'b0;
    end else begin
      sts_q <= sts_d;
      cnt_q <= cnt_q + EXT_W'(tick);
      if (tmr_clr) tgt_q <= (cnt_q + STEP) & ~(STEP - EXT_W'(1));
      if (en_wr) en_q <= wr_data;
      if (ctl_wr) ctl_q <= wr_data & ~(16'(1) << B_SLP);
      if (apm_wr && apm_cmd == APM_ON)  ctl_q[B_SCE] <= 1'b1;
      if (apm_wr && apm_cmd == APM_OFF) ctl_q[B_SCE] <= 1'b0;
      shutdown_req <= slp_off;
      reset_req    <= slp_s3;
      s3_flag      <= s3_flag | slp_s3;
      smi_pulse    <= apm_wr && smi_cfg_en;
    end
  end

  p_tmr_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_TMR) |-> rd_data[31:TMR_W] == '0);
  p_ctl_noslp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[B_SLP]);
  p_tmr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_eff[B_TMR]) |-> $past(sts_wr && wr_data[B_TMR]));
  p_off_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(ctl_wr && wr_data[B_SLP] && wr_data[12:10] == 3'd0));
  p_s3_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s3_flag |=> s3_flag);
  p_smi_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |-> $past(apm_wr && smi_cfg_en));
  p_pwr_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[B_PWR]) |-> $past(en_q[B_PWR] || slp_s3));

endmodule

// File: tb/pm_event_timer_test.sv
module pm_event_timer_test;
  localparam int OVF = 7;
  localparam int NV  = 11;
  localparam logic [64:0] VEC [0:NV-1] = '{
    {1'b1, 16'h0002, 16'h0521, 32'h0},
    {1'b0, 16'h0002, 16'h0000, 32'h0000_0521},
    {1'b1, 16'h0004, 16'h2C05, 32'h0},
    {1'b0, 16'h0004, 16'h0000, 32'h0000_0C05},
    {1'b1, 16'h0006, 16'h1234, 32'h0},
    {1'b0, 16'h0006, 16'h0000, 32'h0},
    {1'b0, 16'h0002, 16'h0000, 32'h0000_0521},
    {1'b1, 16'h0004, 16'h0003, 32'h0},
    {1'b0, 16'h0004, 16'h0000, 32'h0000_0003},
    {1'b0, 16'h003F, 16'h0000, 32'h0},
    {1'b0, 16'h0008, 16'h0000, 32'h0}
  };

  logic clk = 0, rst_n = 0;
  logic [5:0] addr = 0;
  logic wr_en = 0, tick = 0, pwr_btn = 0, apm_wr = 0, smi_cfg_en = 0;
  logic [15:0] wr_data = 0;
  logic [7:0] apm_cmd = 0;
  logic [31:0] rd_data;
  logic sci, shutdown_req, reset_req, s3_flag, smi_pulse;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  pm_event_timer #(.OVF_BIT(OVF)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .pwr_btn(pwr_btn), .apm_wr(apm_wr),
    .apm_cmd(apm_cmd), .smi_cfg_en(smi_cfg_en), .sci(sci),
    .shutdown_req(shutdown_req), .reset_req(reset_req), .s3_flag(s3_flag),
    .smi_pulse(smi_pulse));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic ticks(input int n);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic press;
    pwr_btn = 1; @(negedge clk); pwr_btn = 0;
  endtask

  task automatic apm(input logic [7:0] c);
    apm_cmd = c; apm_wr = 1; @(negedge clk); apm_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    rd("R13 status", 6'h00, 0); rd("R13 enable", 6'h02, 0);
    rd("R13 control", 6'h04, 0); rd("R13 timer", 6'h08, 0);
    chk("R13 outputs", {27'h0, sci, shutdown_req, reset_req, s3_flag, smi_pulse}, 0);

    // R1 R7 R9 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][64]) wr(VEC[i][53:48], VEC[i][47:32]);
      else rd("R1 R7 table", VEC[i][53:48], VEC[i][31:0]);
    end
    chk("R9 other type no action", {29'h0, shutdown_req, reset_req, s3_flag}, 0);

    // R10 R6 R3 power button
    wr(6'h02, 16'h0000); press;
    rd("R10 gated", 6'h00, 0);
    wr(6'h02, 16'h0100); press;
    rd("R10 set", 6'h00, 32'h100); chk("R6 sci pwr", 32'(sci), 1);
    wr(6'h00, 16'h0000); rd("R3 zero keeps", 6'h00, 32'h100);
    wr(6'h00, 16'h0100); rd("R3 clear", 6'h00, 0); chk("R6 sci low", 32'(sci), 0);

    // R2 R4 R5 timer
    wr(6'h02, 16'h0001);
    ticks(5); rd("R2 count", 6'h08, 5);
    ticks(122); rd("R4 before", 6'h00, 0); chk("R6 no timer sci", 32'(sci), 0);
    ticks(1); rd("R4 reached", 6'h00, 1); chk("R6 timer sci", 32'(sci), 1);
    ticks(10);
    wr(6'h02, 16'h0101); press;
    rd("R4 held", 6'h00, 32'h101);
    wr(6'h00, 16'h0001); rd("R3 partial", 6'h00, 32'h100);
    rd("R2 count2", 6'h08, 138);
    ticks(117); rd("R5 before", 6'h00, 32'h100);
    ticks(1); rd("R5 rearm", 6'h00, 32'h101);
    wr(6'h00, 16'h0101); rd("R5 cleared", 6'h00, 0);

    // R11 R12 APM
    wr(6'h04, 16'h0000);
    apm(8'hF1); rd("R11 on", 6'h04, 1); chk("R12 no smi", 32'(smi_pulse), 0);
    apm(8'h33); rd("R11 other", 6'h04, 1);
    apm(8'hF0); rd("R11 off", 6'h04, 0);
    smi_cfg_en = 1; apm(8'h55);
    chk("R12 smi", 32'(smi_pulse), 1);
    @(negedge clk); chk("R12 smi drop", 32'(smi_pulse), 0);
    smi_cfg_en = 0;

    // R8 soft off
    wr(6'h04, 16'h2000);
    chk("R8 pulse", {30'h0, shutdown_req, reset_req}, 32'h2);
    rd("R8 ctl", 6'h04, 0);
    @(negedge clk); chk("R8 drop", 32'(shutdown_req), 0);

    // R9 suspend
    wr(6'h04, 16'h2401);
    chk("R9 pulse", {29'h0, shutdown_req, reset_req, s3_flag}, 32'h3);
    rd("R9 status", 6'h00, 32'h8100); rd("R7 ctl", 6'h04, 32'h401);
    chk("R6 sci wake", 32'(sci), 1);
    repeat (3) @(negedge clk);
    chk("R9 sticky", {30'h0, reset_req, s3_flag}, 32'h1);

    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R13 s3 cleared", 32'(s3_flag), 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule